// File: doc/BRIEF.md
# Bank-Group Command Timing Tracker

This block keeps command spacing limits for every bank of one DDR4-style rank. Each bank holds two absolute cycle stamps: the earliest cycle at which it may accept an activate, and the earliest cycle at which it may accept a column command (read or write). Each bank belongs to a bank group. Bank `b` is in group `b / (NUM_BANKS / NUM_GROUPS)`.

When a command is accepted, the block raises the limits of every bank. Banks in the issuing bank's group get the long same-group spacing. All other banks get the short spacing. A free-running cycle counter is compared with each stored limit to produce per-bank permission flags, which an external scheduler reads. The block does not choose, reorder or hold back commands. Refresh, the rolling activate window and precharge timing are handled elsewhere.

With `NUM_GROUPS` equal to 1, group timing is off. The long delays are then ignored and every bank sees only the short spacing.

Top module: `bg_timing_tracker`

## Requirements
- R1: After reset the cycle counter is zero and all limits are zero, so every bit of `act_ok` and `col_ok` is 1 on the first cycle after reset is released.
- R2: An activate (`cmd_type` 2'b01 with `cmd_valid` high) issued in cycle N to a bank of group G clears `act_ok` of every bank in G, including the issuing bank. Those bits stay low until cycle N + max(T_RRD_L, T_RRD_S). The group of bank b is b / (NUM_BANKS / NUM_GROUPS).
- R3: An activate issued in cycle N raises the activate limit of every bank outside the issuing group to N + T_RRD_S.
- R4: A read (2'b10) or write (2'b11) issued in cycle N holds `col_ok` low for every bank in the issuing group until cycle N + max(T_CCD_L, T_CCD_S).
- R5: A read or write issued in cycle N raises the column limit of every bank outside the issuing group to N + T_CCD_S, which is the burst duration.
- R6: With NUM_GROUPS = 1, all banks use only T_RRD_S and T_CCD_S. The long delays have no effect.
- R7: A stored limit only ever moves later. An update whose new value is earlier than the stored limit leaves the stored limit unchanged.
- R8: An activate changes no column limit, and a read or write changes no activate limit.
- R9: A command with `cmd_valid` low, or with `cmd_type` 2'b00 (no operation), changes no limit.
- R10: A permission bit is 1 exactly when the cycle counter is greater than or equal to that bank's stored limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | A command is issued this cycle |
| cmd_type | input | 2 | 00 no-op, 01 activate, 10 read, 11 write |
| cmd_bank | input | BW | Target bank index |
| act_ok | output | NUM_BANKS | Per-bank activate permitted |
| col_ok | output | NUM_BANKS | Per-bank column command permitted |

## Verification
The bench drives two instances side by side: one with two bank groups and one with group timing turned off. Both instances see an activate sweep and a read/write sweep that each start from reset for every bank. These sweeps tell the long same-group window apart from the short cross-group window, and show that each command kind touches only its own limit. A fixed sequence of overlapping activates shows that a later short update cannot pull a long limit earlier. A mixed stream of interleaved commands and no-ops, together with deasserted-valid stimulus, shows that ignored commands leave every flag as it was.

// File: rtl/bg_timing_tracker.sv
module bg_timing_tracker #(
  parameter int NUM_BANKS  = 16,
  parameter int NUM_GROUPS = 4,
  parameter int CNT_W      = 32,
  parameter int T_RRD_S    = 4,
  parameter int T_RRD_L    = 6,
  parameter int T_CCD_S    = 4,
  parameter int T_CCD_L    = 6,
  localparam int BW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  input  logic [1:0]           cmd_type,
  input  logic [BW-1:0]        cmd_bank,
  output logic [NUM_BANKS-1:0] act_ok,
  output logic [NUM_BANKS-1:0] col_ok
);

  localparam int  BPG      = NUM_BANKS / NUM_GROUPS;
  localparam bit  GRP_ON   = NUM_GROUPS > 1;
  localparam int  RRD_SAME = (GRP_ON && T_RRD_L > T_RRD_S) ? T_RRD_L : T_RRD_S;
  localparam int  CCD_SAME = (GRP_ON && T_CCD_L > T_CCD_S) ? T_CCD_L : T_CCD_S;

  logic [CNT_W-1:0] now;
  logic [BW-1:0]    issue_grp;
  logic             is_act, is_col;
  logic [CNT_W-1:0] act_same, act_other, col_same, col_other;

  always_ff @(posedge clk) begin
    if (!rst_n) now <= '0;
    else        now <= now + 1'b1;
  end

  assign is_act    = cmd_valid && (cmd_type == 2'b01);
  assign is_col    = cmd_valid && cmd_type[1];
  assign issue_grp = cmd_bank / BW'(BPG);
  assign act_same  = now + CNT_W'(RRD_SAME);
  assign act_other = now + CNT_W'(T_RRD_S);
  assign col_same  = now + CNT_W'(CCD_SAME);
  assign col_other = now + CNT_W'(T_CCD_S);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam logic [BW-1:0] GRP = BW'(b / BPG);
    logic [CNT_W-1:0] act_lim, col_lim;
    logic [CNT_W-1:0] act_new, col_new;
    logic             in_grp;

    assign in_grp  = (issue_grp == GRP);
    assign act_new = in_grp ? act_same : act_other;
    assign col_new = in_grp ? col_same : col_other;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        act_lim <= '0;
        col_lim <= '0;
      end else begin
        if (is_act && act_new > act_lim) act_lim <= act_new;
        if (is_col && col_new > col_lim) col_lim <= col_new;
      end
    end

    assign act_ok[b] = (now >= act_lim);
    assign col_ok[b] = (now >= col_lim);
  end

endmodule

module bg_timing_tracker_chk #(
  parameter int NUM_BANKS  = 16,
  parameter int NUM_GROUPS = 4,
  parameter int T_RRD_S    = 4,
  parameter int T_RRD_L    = 6,
  parameter int T_CCD_S    = 4,
  parameter int T_CCD_L    = 6,
  parameter int BW         = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cmd_valid,
  input logic [1:0]           cmd_type,
  input logic [BW-1:0]        cmd_bank,
  input logic [NUM_BANKS-1:0] act_ok,
  input logic [NUM_BANKS-1:0] col_ok
);
  localparam int BPG = NUM_BANKS / NUM_GROUPS;
  localparam int RS  = (NUM_GROUPS > 1 && T_RRD_L > T_RRD_S) ? T_RRD_L : T_RRD_S;
  localparam int CS  = (NUM_GROUPS > 1 && T_CCD_L > T_CCD_S) ? T_CCD_L : T_CCD_S;

  logic act_cmd, col_cmd;
  assign act_cmd = cmd_valid && cmd_type == 2'b01;
  assign col_cmd = cmd_valid && cmd_type[1];

  a_r1_reset_all_ok: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (&act_ok && &col_ok));

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
    if (RS > 1) begin : g_rs
      a_r2_same_grp_act_block: assert property (@(posedge clk) disable iff (!rst_n)
        (act_cmd && (int'(cmd_bank) / BPG) == (b / BPG)) |=> !act_ok[b]);
    end
    if (T_RRD_S > 1) begin : g_rd
      a_r3_other_grp_act_block: assert property (@(posedge clk) disable iff (!rst_n)
        act_cmd |=> !act_ok[b]);
    end
    if (CS > 1) begin : g_cs
      a_r4_same_grp_col_block: assert property (@(posedge clk) disable iff (!rst_n)
        (col_cmd && (int'(cmd_bank) / BPG) == (b / BPG)) |=> !col_ok[b]);
    end
    a_r8_act_drop_needs_act: assert property (@(posedge clk) disable iff (!rst_n)
      (act_ok[b] && !act_cmd) |=> act_ok[b]);
    a_r8_col_drop_needs_col: assert property (@(posedge clk) disable iff (!rst_n)
      (col_ok[b] && !col_cmd) |=> col_ok[b]);
  end
endmodule

bind bg_timing_tracker bg_timing_tracker_chk #(
  .NUM_BANKS(NUM_BANKS), .NUM_GROUPS(NUM_GROUPS),
  .T_RRD_S(T_RRD_S), .T_RRD_L(T_RRD_L), .T_CCD_S(T_CCD_S), .T_CCD_L(T_CCD_L),
  .BW(BW)
) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_type(cmd_type),
  .cmd_bank(cmd_bank), .act_ok(act_ok), .col_ok(col_ok)
);

// File: tb/bg_timing_tracker_tb_top.sv
`timescale 1ns/1ps
module bg_timing_tracker_tb_top;
  localparam int NB = 8;
  localparam int RRD_S = 2, RRD_L = 5, CCD_S = 3, CCD_L = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_type = 2'b00;
  logic [2:0] cmd_bank = '0;
  logic [NB-1:0] act_g, col_g, act_f, col_f;

  int checks = 0, errors = 0;
  int tb_now = 0;
  int m_act [2][NB];
  int m_col [2][NB];
  int ngrp [2] = '{2, 1};

  always #2.5 clk = ~clk;

  bg_timing_tracker #(.NUM_BANKS(NB), .NUM_GROUPS(2), .CNT_W(16),
    .T_RRD_S(RRD_S), .T_RRD_L(RRD_L), .T_CCD_S(CCD_S), .T_CCD_L(CCD_L)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_type(cmd_type),
    .cmd_bank(cmd_bank), .act_ok(act_g), .col_ok(col_g));

  bg_timing_tracker #(.NUM_BANKS(NB), .NUM_GROUPS(1), .CNT_W(16),
    .T_RRD_S(RRD_S), .T_RRD_L(RRD_L), .T_CCD_S(CCD_S), .T_CCD_L(CCD_L)) dut_flat_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_type(cmd_type),
    .cmd_bank(cmd_bank), .act_ok(act_f), .col_ok(col_f));

  task automatic cmp(string tag, string what, logic [NB-1:0] got, logic [NB-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s at cycle %0d: got %b expected %b", tag, what, tb_now, got, exp);
    end
  endtask

  task automatic check_all(string tag);
    logic [NB-1:0] ea [2];
    logic [NB-1:0] ec [2];
    for (int d = 0; d < 2; d++)
      for (int b = 0; b < NB; b++) begin
        ea[d][b] = tb_now >= m_act[d][b];
        ec[d][b] = tb_now >= m_col[d][b];
      end
    cmp(tag, "grouped act_ok", act_g, ea[0]);
    cmp(tag, "grouped col_ok", col_g, ec[0]);
    cmp(tag, "flat act_ok",    act_f, ea[1]);
    cmp(tag, "flat col_ok",    col_f, ec[1]);
  endtask

  task automatic model(logic v, logic [1:0] t, int bank);
    for (int d = 0; d < 2; d++) begin
      int bpg = NB / ngrp[d];
      for (int b = 0; b < NB; b++) begin
        bit same = (b / bpg) == (bank / bpg);
        int la = (ngrp[d] > 1 && same) ? RRD_L : RRD_S;
        int lc = (ngrp[d] > 1 && same) ? CCD_L : CCD_S;
        if (v && t == 2'b01 && tb_now + la > m_act[d][b]) m_act[d][b] = tb_now + la;
        if (v && t[1] && tb_now + lc > m_col[d][b]) m_col[d][b] = tb_now + lc;
      end
    end
  endtask

  task automatic step(string tag, logic v, logic [1:0] t, int bank);
    @(negedge clk);
    check_all(tag);
    cmd_valid = v;
    cmd_type  = t;
    cmd_bank  = 3'(bank);
    @(posedge clk);
    model(v, t, bank);
    tb_now++;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cmd_valid = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    tb_now = 0;
    for (int d = 0; d < 2; d++)
      for (int b = 0; b < NB; b++) begin
        m_act[d][b] = 0;
        m_col[d][b] = 0;
      end
  endtask

  initial begin
    do_reset();
    check_all("R1 R10");

    for (int b = 0; b < NB; b++) begin
      do_reset();
      step("R2 R3 R6", 1'b1, 2'b01, b);
      for (int i = 0; i < 8; i++) step("R2 R3 R6 R8 R10", 1'b0, 2'b00, 0);
    end

    for (int b = 0; b < NB; b++)
      for (int k = 0; k < 2; k++) begin
        do_reset();
        step("R4 R5 R6", 1'b1, k ? 2'b11 : 2'b10, b);
        for (int i = 0; i < 9; i++) step("R4 R5 R6 R8 R10", 1'b0, 2'b00, 0);
      end

    do_reset();
    step("R7", 1'b1, 2'b01, 0);
    step("R7", 1'b0, 2'b00, 0);
    step("R7", 1'b1, 2'b01, 5);
    step("R7", 1'b1, 2'b10, 1);
    step("R7", 1'b0, 2'b00, 0);
    step("R7", 1'b1, 2'b11, 6);
    for (int i = 0; i < 8; i++) step("R7", 1'b0, 2'b00, 0);

    do_reset();
    for (int b = 0; b < NB; b++) step("R9", 1'b1, 2'b00, b);
    for (int b = 0; b < NB; b++) step("R9", 1'b0, 2'(b % 4), b);
    step("R9", 1'b0, 2'b00, 0);

    do_reset();
    for (int i = 0; i < 48; i++) step("R2 R4 R7 R8", 1'b1, 2'(i % 4), (i * 3) % NB);
    for (int i = 0; i < 8; i++) step("R2 R4 R7 R8", 1'b0, 2'b00, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired: got hang expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule